// File: doc/BRIEF.md
# Dual-Channel Serial Converter Code Loader

This block is the digital front end of a two-channel 12-bit converter. A host sends a 24-bit word one bit at a time on a serial clock and data line, most significant bit first. The word is collected in a shift register. Two active-low update strobes then copy one half of that register, or both halves at once, into the two code registers that drive the converters. An active-low select line gates all serial and update activity. An active-low clear zeroes every register at once.

All serial-side inputs are slow, asynchronous signals. Each one passes through a synchronizer into the fast system clock domain. A falling edge of the serial clock is found there by edge detection, and that edge captures one data bit. Each code register raises a one-cycle done pulse in the cycle its new value appears. A full frame is the code for channel B, most significant bit first, followed by the code for channel A, most significant bit first.

Top module: `dual_dac_loader`

## Requirements
- R1: While `clr_n` is low, `code_a`, `code_b`, `done_a`, `done_b` and the shift register are zero, with no clock edge needed. After `clr_n` rises, the registers stay zero until new data is loaded. A clear partway through a frame discards the bits already shifted.
- R2: With `cs_n` low and both strobes high, each falling edge of `sclk` captures `sdata`. The captured bit enters shift-register position 23, and every earlier bit moves one position toward position 0. `sclk` must run at or below one quarter of the `clk` rate.
- R3: While `cs_n` is high, `sclk` edges do not change the shift register. Strobes have no effect, and neither code nor done output changes.
- R4: When `upd_a_n` falls with `cs_n` low, `code_a` loads shift-register positions 12 to 23. Position 12 becomes the code's MSB and position 23 its LSB, so `code_a` equals the last 12 bits of the frame in the order they were sent.
- R5: When `upd_b_n` falls with `cs_n` low, `code_b` loads shift-register positions 0 to 11. Position 0 becomes the code's MSB and position 11 its LSB, so `code_b` equals the first 12 bits of the frame in the order they were sent.
- R6: When both strobes become active in the same cycle with `cs_n` low, both code registers load in the same `clk` cycle.
- R7: A code register changes only on a load. Each load raises that channel's done output for exactly one `clk` cycle, in the cycle the new code appears. A strobe held low loads only once.
- R8: While either strobe is low, `sclk` edges do not shift the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; it samples every other input |
| clr_n | input | 1 | Active-low clear: asserts asynchronously, releases synchronously |
| sclk | input | 1 | Serial clock; a bit is taken on its falling edge |
| sdata | input | 1 | Serial data, MSB of the frame first |
| cs_n | input | 1 | Active-low select that gates shifting and updates |
| upd_a_n | input | 1 | Active-low update strobe for channel A |
| upd_b_n | input | 1 | Active-low update strobe for channel B |
| code_a | output | CODE_W | Channel A converter code |
| code_b | output | CODE_W | Channel B converter code |
| done_a | output | 1 | One-cycle pulse when code_a has loaded |
| done_b | output | 1 | One-cycle pulse when code_b has loaded |

## Verification
The bench first targets the bit order inside each half of the frame. A design that does not reverse the bits would present every code mirrored, and random frames expose this at once. It then targets shifting while `cs_n` is high or while a strobe is held low. A design that shifts anyway would load a code built from junk bits. It checks that a held strobe loads only once, since a level-triggered load would produce repeated done pulses. Last, it applies a clear in the middle of a frame. A shifter that is not cleared would carry stale bits into the next partial frame's codes.

// File: rtl/dl_pkg.sv
package dl_pkg;

  // Bundle of slow serial-side controls taken into the system clock domain
  typedef struct packed {
    logic sclk;
    logic sdata;
    logic cs_n;
    logic upd_a_n;
    logic upd_b_n;
  } ctl_t;

  localparam ctl_t CTL_IDLE = '{sclk: 1'b0, sdata: 1'b0, cs_n: 1'b1,
                                upd_a_n: 1'b1, upd_b_n: 1'b1};

endpackage

// File: rtl/dl_sync.sv
module dl_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg;
  logic [STAGES-1:0][W-1:0] stg_nxt;

  always_comb begin
    stg_nxt = {stg[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg <= {STAGES{RST_VAL}};
    else        stg <= stg_nxt;
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/dl_shifter.sv
module dl_shifter #(
  parameter int FRAME_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift_en,
  input  logic               din,
  output logic [FRAME_W-1:0] sr
);

  logic [FRAME_W-1:0] sr_nxt;

  // New bit enters the top position, older bits move toward position 0
  always_comb begin
    sr_nxt = sr;
    if (shift_en) sr_nxt = {din, sr[FRAME_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '0;
    else        sr <= sr_nxt;
  end

endmodule

// File: rtl/dl_channel.sv
module dl_channel #(
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CODE_W-1:0] half,
  output logic [CODE_W-1:0] code,
  output logic              done
);

  logic [CODE_W-1:0] flipped;
  logic [CODE_W-1:0] code_nxt;

  // The lowest index of the half carries the code's MSB
  for (genvar i = 0; i < CODE_W; i++) begin : g_rev
    assign flipped[CODE_W-1-i] = half[i];
  end

  always_comb begin
    code_nxt = code;
    if (load) code_nxt = flipped;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code <= '0;
      done <= 1'b0;
    end else begin
      code <= code_nxt;
      done <= load;
    end
  end

endmodule

// File: rtl/dual_dac_loader.sv
module dual_dac_loader
  import dl_pkg::*;
#(
  parameter int CODE_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              clr_n,
  input  logic              sclk,
  input  logic              sdata,
  input  logic              cs_n,
  input  logic              upd_a_n,
  input  logic              upd_b_n,
  output logic [CODE_W-1:0] code_a,
  output logic [CODE_W-1:0] code_b,
  output logic              done_a,
  output logic              done_b
);

  localparam int FRAME_W = 2 * CODE_W;
  localparam int NCH     = 2;
  localparam int CH_B    = 0;  // lower half of the frame register
  localparam int CH_A    = 1;  // upper half of the frame register

  // Clear: asynchronous assertion, synchronous release
  logic [1:0] clr_q;
  logic [1:0] clr_nxt;
  logic       rst_q_n;

  always_comb clr_nxt = {clr_q[0], 1'b1};

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) clr_q <= '0;
    else        clr_q <= clr_nxt;
  end

  assign rst_q_n = clr_q[1];

  // Input synchronization
  ctl_t raw;
  ctl_t syn;

  assign raw = '{sclk: sclk, sdata: sdata, cs_n: cs_n,
                 upd_a_n: upd_a_n, upd_b_n: upd_b_n};

  dl_sync #(
    .W       ($bits(ctl_t)),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (CTL_IDLE)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_q_n),
    .d     (raw),
    .q     (syn)
  );

  // Edge detection and control decode
  logic           sclk_q, ua_q, ub_q;
  logic           sclk_fall, selected, ua_lvl, ub_lvl, shift_en;
  logic [NCH-1:0] load;

  always_comb begin
    sclk_fall  = sclk_q & ~syn.sclk;
    selected   = ~syn.cs_n;
    ua_lvl     = selected & ~syn.upd_a_n;
    ub_lvl     = selected & ~syn.upd_b_n;
    load[CH_A] = ua_lvl & ~ua_q;
    load[CH_B] = ub_lvl & ~ub_q;
    shift_en   = sclk_fall & selected & syn.upd_a_n & syn.upd_b_n;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      sclk_q <= 1'b0;
      ua_q   <= 1'b0;
      ub_q   <= 1'b0;
    end else begin
      sclk_q <= syn.sclk;
      ua_q   <= ua_lvl;
      ub_q   <= ub_lvl;
    end
  end

  // Frame register
  logic [FRAME_W-1:0] sr;

  dl_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .shift_en (shift_en),
    .din      (syn.sdata),
    .sr       (sr)
  );

  // Channel code registers
  logic [NCH-1:0][CODE_W-1:0] codes;
  logic [NCH-1:0]             dones;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    dl_channel #(.CODE_W(CODE_W)) u_ch (
      .clk   (clk),
      .rst_n (rst_q_n),
      .load  (load[ch]),
      .half  (sr[ch*CODE_W +: CODE_W]),
      .code  (codes[ch]),
      .done  (dones[ch])
    );
  end

  assign code_a = codes[CH_A];
  assign code_b = codes[CH_B];
  assign done_a = dones[CH_A];
  assign done_b = dones[CH_B];

endmodule

// File: rtl/dl_checker.sv
module dl_checker #(
  parameter int CODE_W  = 12,
  parameter int FRAME_W = 24
) (
  input logic               clk,
  input logic               rst_q_n,
  input logic               s_cs_n,
  input logic               s_upd_a_n,
  input logic               s_upd_b_n,
  input logic [FRAME_W-1:0] sr,
  input logic [CODE_W-1:0]  code_a,
  input logic [CODE_W-1:0]  code_b,
  input logic               done_a,
  input logic               done_b
);

  AST_HOLD_A: assert property (@(posedge clk) disable iff (!rst_q_n)
    !$stable(code_a) |-> done_a);  // R7
  AST_HOLD_B: assert property (@(posedge clk) disable iff (!rst_q_n)
    !$stable(code_b) |-> done_b);  // R7
  AST_PULSE_A: assert property (@(posedge clk) disable iff (!rst_q_n)
    done_a |=> !done_a);  // R7
  AST_PULSE_B: assert property (@(posedge clk) disable iff (!rst_q_n)
    done_b |=> !done_b);  // R7
  AST_CS_BLOCK: assert property (@(posedge clk) disable iff (!rst_q_n)
    s_cs_n |=> $stable(sr));  // R3
  AST_STROBE_BLOCK: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!s_upd_a_n || !s_upd_b_n) |=> $stable(sr));  // R8
  AST_LOAD_SRC_A: assert property (@(posedge clk) disable iff (!rst_q_n)
    done_a |-> (!$past(s_cs_n) && !$past(s_upd_a_n)));  // R4
  AST_LOAD_SRC_B: assert property (@(posedge clk) disable iff (!rst_q_n)
    done_b |-> (!$past(s_cs_n) && !$past(s_upd_b_n)));  // R5

endmodule

bind dual_dac_loader dl_checker #(.CODE_W(CODE_W), .FRAME_W(FRAME_W)) u_chk (
  .clk       (clk),
  .rst_q_n   (rst_q_n),
  .s_cs_n    (syn.cs_n),
  .s_upd_a_n (syn.upd_a_n),
  .s_upd_b_n (syn.upd_b_n),
  .sr        (sr),
  .code_a    (code_a),
  .code_b    (code_b),
  .done_a    (done_a),
  .done_b    (done_b)
);

// File: tb/dual_dac_loader_test.sv
module dual_dac_loader_test;

  localparam int W = 12;

  logic clk = 1'b0;
  logic clr_n = 1'b0, sclk = 1'b0, sdata = 1'b0;
  logic cs_n = 1'b1, upd_a_n = 1'b1, upd_b_n = 1'b1;
  logic [W-1:0] code_a, code_b;
  logic done_a, done_b;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit mon_on = 0;
  logic [2*W-1:0] model;   // expected frame register contents
  logic [W-1:0] qa[$];
  logic [W-1:0] qb[$];

  always #5 clk = ~clk;

  dual_dac_loader uut (
    .clk(clk), .clr_n(clr_n), .sclk(sclk), .sdata(sdata), .cs_n(cs_n),
    .upd_a_n(upd_a_n), .upd_b_n(upd_b_n), .code_a(code_a), .code_b(code_b),
    .done_a(done_a), .done_b(done_b)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R2: bit enters position 23 when shifting is allowed
  task automatic send_bit(input logic b);
    @(negedge clk);
    sdata = b;
    sclk  = 1'b1;
    idle(4);
    sclk = 1'b0;
    idle(4);
    if (!cs_n && upd_a_n && upd_b_n) model = {b, model[2*W-1:1]};
  endtask

  task automatic send_frame(input logic [2*W-1:0] f);
    for (int i = 2*W-1; i >= 0; i--) send_bit(f[i]);
  endtask

  function automatic logic [W-1:0] half_rev(input int base);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[W-1-i] = model[base+i];
    return r;
  endfunction

  // Driver: pulses the strobes, pushes expected codes to the scoreboard
  task automatic update(input bit a, input bit b);
    int ca, cb;
    ca = -1; cb = -1;
    @(negedge clk);
    if (!cs_n) begin
      if (a) qa.push_back(half_rev(W));
      if (b) qb.push_back(half_rev(0));
    end
    upd_a_n = !a;
    upd_b_n = !b;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      if (done_a && ca < 0) ca = c;
      if (done_b && cb < 0) cb = c;
    end
    upd_a_n = 1'b1;
    upd_b_n = 1'b1;
    idle(4);
    if (a && b && !cs_n) check(ca == cb && ca >= 0, "R6 same-cycle load", ca, cb);
  endtask

  // Monitor: pops scoreboard entries on each done pulse
  logic pa = 1'b0, pb = 1'b0;
  always @(negedge clk) begin
    if (mon_on) begin
      if (done_a) begin
        check(!pa, "R7 done_a width", 32'(pa), 0);
        if (qa.size() == 0) check(0, "R3 R7 unexpected done_a", 1, 0);
        else begin
          logic [W-1:0] e;
          e = qa.pop_front();
          check(code_a === e, "R2 R4 code_a", 32'(code_a), 32'(e));
        end
      end
      if (done_b) begin
        check(!pb, "R7 done_b width", 32'(pb), 0);
        if (qb.size() == 0) check(0, "R3 R7 unexpected done_b", 1, 0);
        else begin
          logic [W-1:0] e;
          e = qb.pop_front();
          check(code_b === e, "R2 R5 code_b", 32'(code_b), 32'(e));
        end
      end
    end
    pa <= done_a;
    pb <= done_b;
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [W-1:0] sa, sb;
    model = '0;
    idle(5);
    clr_n = 1'b1;
    idle(6);
    check(code_a == 0 && code_b == 0 && !done_a && !done_b, "R1 reset state",
          {code_a, code_b}, 0);
    mon_on = 1;
    cs_n = 1'b0;

    // directed frame: B = 0xA5C, A = 0x3E1
    send_frame({12'hA5C, 12'h3E1});
    update(1, 1);
    check(code_b == 12'hA5C, "R5 directed code_b", 32'(code_b), 32'hA5C);
    check(code_a == 12'h3E1, "R4 directed code_a", 32'(code_a), 32'h3E1);

    for (int k = 0; k < 14; k++) begin
      int m;
      send_frame(24'($urandom));
      m = $urandom_range(0, 2);
      update(m != 1, m != 0);
    end

    // R3: select high blocks shifting and strobes
    sa = code_a; sb = code_b;
    cs_n = 1'b1;
    send_frame(24'($urandom));
    update(1, 1);
    check(code_a == sa && code_b == sb, "R3 strobe ignored", {code_a, code_b}, {sa, sb});
    cs_n = 1'b0;
    idle(4);
    update(1, 1);

    // R8: strobe held low blocks shifting; held strobe loads once (R7)
    send_frame(24'($urandom));
    @(negedge clk);
    qb.push_back(half_rev(0));
    upd_b_n = 1'b0;
    idle(4);
    for (int i = 0; i < 12; i++) send_bit(1'($urandom));
    upd_b_n = 1'b1;
    idle(4);
    update(1, 0);

    // R1: clear in the middle of a frame
    for (int i = 0; i < 10; i++) send_bit(1'b1);
    @(negedge clk);
    clr_n = 1'b0;
    #1;
    check(code_a == 0 && code_b == 0 && !done_a && !done_b, "R1 async clear",
          {code_a, code_b}, 0);
    model = '0;
    idle(4);
    clr_n = 1'b1;
    idle(6);
    check(code_a == 0 && code_b == 0, "R1 after release", {code_a, code_b}, 0);
    for (int i = 0; i < 6; i++) send_bit(1'b1);
    update(1, 1);
    send_frame(24'($urandom));
    update(1, 1);

    idle(10);
    check(qa.size() == 0 && qb.size() == 0, "R7 every load pulsed",
          qa.size() + qb.size(), 0);
    summary();
  end

endmodule